// File: doc/BRIEF.md
# Boot-overlay memory mapper

This block sits between an 8-bit CPU bus with a 16-bit address and two memories: a 256 KB flash device and up to 48 KB of RAM, built from 16 KB banks. It decodes each memory cycle into one chip select. For flash cycles it also drives the upper flash address bits. The low flash address bits come straight from the CPU address bus.

After a hard reset the CPU must find code at address zero. The mapper therefore shows the last 4 KB page of flash, at flash offset 0x3F000, in two places: in the bottom 4 KB (0x0000–0x0FFF) and at 0xE000–0xEFFF. The top 16 KB of CPU space, 0xC000–0xFFFF, is a paged window into flash. A 4-bit page register picks which 16 KB flash page it shows.

Boot code writes a single I/O control byte to change the mapping. That byte switches the overlay off, which exposes RAM at the bottom and the paged window at 0xE000, and it also loads the page register. Bus timing and wait states are handled elsewhere.

Top module: `bootOverlayMapper`

## Requirements
- R1: After a synchronous reset the overlay is on and the page register holds 15. A read of 0xC000 then gives upper flash bits (flash address bits 17:12) of 0x3C.
- R2: While the overlay is on, a memory read of 0x0000–0x0FFF asserts the flash select and drives upper flash bits 0x3F (flash 0x3F000 + address bits 11:0).
- R3: While the overlay is on, a memory read of 0xE000–0xEFFF asserts the flash select with upper bits 0x3F. This takes priority over the paged window.
- R4: An I/O write (IORQ and WR low, MREQ high) whose port, address bits 7:0, is in 0 to 32 loads the mapping on the next clock edge. Data bit 6 = 1 turns the overlay off and bit 6 = 0 turns it back on. A write to port 33 or above changes nothing.
- R5: The same control write loads data bits 3:0 into the page register. A read of 0xC000–0xFFFF outside the overlay drives upper flash bits {page, address bits 13:12}.
- R6: Outside the overlay, 0x0000–0xBFFF is RAM. Address bits 15:14 pick the bank, and bank b asserts ramSelN[b] low. Banks at or above the configured bank count get no select.
- R7: The flash select is asserted only on reads. A memory write that falls in a flash-mapped region asserts no select and no write enable. ramWeN goes low only for a write to RAM.
- R8: At most one select is low at a time. No select is low unless MREQ is low and exactly one of RD or WR is low.
- R9: Reset is synchronous. Pulling rstN low changes the mapping only at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| mreqN | input | 1 | Memory request, active low |
| iorqN | input | 1 | I/O request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 16 | CPU address bus |
| dataIn | input | 8 | CPU data bus, used by control writes |
| romSelN | output | 1 | Flash chip select, active low |
| ramSelN | output | 3 | RAM bank selects, active low, one per 16 KB bank |
| ramWeN | output | 1 | RAM write enable, active low |
| flashHi | output | 6 | Flash address bits 17:12 |

## Verification
The bench looks at the boundaries where one region hands over to the next. These are 0x0FFF/0x1000, the 0xE000 page against the rest of the window, and 0xBFFF/0xC000. A mapper that got the overlay priority wrong would show the paged window at 0xE000 right after reset and fail to boot.

It writes into flash-mapped regions. A design that passed those writes through would corrupt RAM or assert a select that no memory cycle asked for.

It writes the control byte to port 33 and to port 32. An off-by-one port decode would show up as a mapping change in the wrong case.

It lowers rstN between clock edges and samples the outputs before the next edge. An asynchronous reset would be visible there as an early change of the mapping.

// File: rtl/bootMapPkg.sv
package bootMapPkg;

  // Per-cycle qualifiers from the control side to the datapath
  typedef struct packed {
    logic memRd;    // memory read cycle
    logic memWr;    // memory write cycle
    logic cfgLoad;  // control-port write, load mapping this edge
  } mapStrobe_t;

  // Region a memory cycle lands in
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BOOT_LO,
    TGT_BOOT_HI,
    TGT_PAGED,
    TGT_RAM
  } mapTarget_e;

endpackage

// File: rtl/bootMapCtrl.sv
module bootMapCtrl
  import bootMapPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PORT_W    = 8,
  parameter int PORT_LAST = 32
) (
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  output mapStrobe_t        strobe
);

  logic [PORT_W-1:0] portNum;
  logic              portHit;
  logic              unusedAddrHi;

  assign portNum      = addr[PORT_W-1:0];
  assign portHit      = (int'(portNum) <= PORT_LAST);
  assign unusedAddrHi = ^addr[ADDR_W-1:PORT_W];

  always_comb begin
    strobe         = '0;
    // exactly one of RD/WR must be low for a valid memory cycle
    strobe.memRd   = !mreqN && !rdN && wrN;
    strobe.memWr   = !mreqN && !wrN && rdN;
    strobe.cfgLoad = !iorqN && mreqN && !wrN && portHit;
  end

endmodule

// File: rtl/bootMapDatapath.sv
module bootMapDatapath
  import bootMapPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FLASH_AW  = 18,
  parameter int PAGE_AW   = 12,
  parameter int WIN_AW    = 14,
  parameter int RAM_BANKS = 3,
  parameter int OVL_BIT   = 6,
  parameter int HI_BOOT   = 14
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  mapStrobe_t                      strobe,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               dataIn,
  output logic                            romSelN,
  output logic [RAM_BANKS-1:0]            ramSelN,
  output logic                            ramWeN,
  output logic [FLASH_AW-PAGE_AW-1:0]     flashHi
);

  localparam int SEG_W   = FLASH_AW - WIN_AW;
  localparam int HI_W    = FLASH_AW - PAGE_AW;
  localparam int PG_W    = ADDR_W - PAGE_AW;
  localparam int BANK_W  = ADDR_W - WIN_AW;
  localparam int WIN_IDX = (1 << BANK_W) - 1;

  logic              overlayOn;
  logic [SEG_W-1:0]  segReg;
  logic [PG_W-1:0]   pageIdx;
  logic [BANK_W-1:0] bankIdx;
  logic              anyCycle;
  mapTarget_e        target;
  logic              unusedData;

  assign pageIdx    = addr[ADDR_W-1:PAGE_AW];
  assign bankIdx    = addr[ADDR_W-1:WIN_AW];
  assign anyCycle   = strobe.memRd || strobe.memWr;
  assign unusedData = ^dataIn;

  // Mapping state, synchronous reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overlayOn <= 1'b1;
      segReg    <= '1;
    end else if (strobe.cfgLoad) begin
      overlayOn <= !dataIn[OVL_BIT];
      segReg    <= dataIn[SEG_W-1:0];
    end
  end

  // Region decode, overlay first
  always_comb begin
    target = TGT_NONE;
    if (anyCycle) begin
      if (overlayOn && pageIdx == '0)
        target = TGT_BOOT_LO;
      else if (overlayOn && pageIdx == PG_W'(HI_BOOT))
        target = TGT_BOOT_HI;
      else if (bankIdx == BANK_W'(WIN_IDX))
        target = TGT_PAGED;
      else if (int'(bankIdx) < RAM_BANKS)
        target = TGT_RAM;
    end
  end

  always_comb begin
    romSelN = !(strobe.memRd &&
                (target == TGT_BOOT_LO || target == TGT_BOOT_HI ||
                 target == TGT_PAGED));
    if (target == TGT_PAGED)
      flashHi = {segReg, addr[WIN_AW-1:PAGE_AW]};
    else
      flashHi = '1;
    ramWeN = !(target == TGT_RAM && strobe.memWr);
  end

  for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
    assign ramSelN[b] = !(target == TGT_RAM && bankIdx == BANK_W'(b));
  end

  // Checks next to the decode they guard
  p_one_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~romSelN, ~ramSelN}) <= 1);

  p_sel_needs_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!romSelN || ramSelN != '1) |-> anyCycle);

  p_rom_read_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    !romSelN |-> strobe.memRd);

  p_we_only_ram_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (strobe.memWr && ramSelN != '1));

  p_cfg_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgLoad |=> (overlayOn == !$past(dataIn[OVL_BIT])));

  p_seg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgLoad |=> $stable(segReg));

  p_reset_defaults_r9: assert property (@(posedge clk)
    !rstN |=> (overlayOn && segReg == '1));

  p_boot_hi_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overlayOn && strobe.memRd && pageIdx == PG_W'(HI_BOOT)) |->
      (!romSelN && flashHi == HI_W'('1)));

endmodule

// File: rtl/bootOverlayMapper.sv
module bootOverlayMapper
  import bootMapPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FLASH_AW  = 18,
  parameter int RAM_BANKS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        mreqN,
  input  logic                        iorqN,
  input  logic                        rdN,
  input  logic                        wrN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           dataIn,
  output logic                        romSelN,
  output logic [RAM_BANKS-1:0]        ramSelN,
  output logic                        ramWeN,
  output logic [FLASH_AW-12-1:0]      flashHi
);

  mapStrobe_t strobe;

  bootMapCtrl #(
    .ADDR_W    (ADDR_W),
    .PORT_W    (8),
    .PORT_LAST (32)
  ) u_ctrl (
    .mreqN  (mreqN),
    .iorqN  (iorqN),
    .rdN    (rdN),
    .wrN    (wrN),
    .addr   (addr),
    .strobe (strobe)
  );

  bootMapDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FLASH_AW  (FLASH_AW),
    .PAGE_AW   (12),
    .WIN_AW    (14),
    .RAM_BANKS (RAM_BANKS),
    .OVL_BIT   (6),
    .HI_BOOT   (14)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addr    (addr),
    .dataIn  (dataIn),
    .romSelN (romSelN),
    .ramSelN (ramSelN),
    .ramWeN  (ramWeN),
    .flashHi (flashHi)
  );

endmodule

// File: tb/bootOverlayMapper_test.sv
module bootOverlayMapper_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mreqN = 1'b1, iorqN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        romSelN;
  logic [2:0]  ramSelN;
  logic        ramWeN;
  logic [5:0]  flashHi;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  bootOverlayMapper uut (
    .clk(clk), .rstN(rstN), .mreqN(mreqN), .iorqN(iorqN), .rdN(rdN),
    .wrN(wrN), .addr(addr), .dataIn(dataIn), .romSelN(romSelN),
    .ramSelN(ramSelN), .ramWeN(ramWeN), .flashHi(flashHi)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mreqN = 1; iorqN = 1; rdN = 1; wrN = 1;
  endtask

  // memory read: expect selects and, for flash, the upper bits
  task automatic memRead(input logic [15:0] a, input logic expRom,
                         input logic [2:0] expRam, input logic [5:0] expHi,
                         input string tag);
    @(negedge clk);
    addr = a; mreqN = 0; rdN = 0; wrN = 1; iorqN = 1;
    #2;
    chk({tag, " romSelN"}, romSelN, expRom);
    chk({tag, " ramSelN"}, ramSelN, expRam);
    chk({tag, " ramWeN"},  ramWeN, 1);
    if (!expRom) chk({tag, " flashHi"}, flashHi, expHi);
    idle();
  endtask

  task automatic memWrite(input logic [15:0] a, input logic [2:0] expRam,
                          input logic expWe, input string tag);
    @(negedge clk);
    addr = a; mreqN = 0; rdN = 1; wrN = 0; iorqN = 1;
    #2;
    chk({tag, " romSelN"}, romSelN, 1);
    chk({tag, " ramSelN"}, ramSelN, expRam);
    chk({tag, " ramWeN"},  ramWeN, expWe);
    idle();
  endtask

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    addr = {8'h00, port}; dataIn = d; mreqN = 1; iorqN = 0; wrN = 0; rdN = 1;
    #2;
    chk("R8 io cycle romSelN", romSelN, 1);
    chk("R8 io cycle ramSelN", ramSelN, 3'b111);
    @(posedge clk);
    idle();
  endtask

  task automatic testReset();
    // R1 R2 R3: boot overlay and page 15 after reset
    memRead(16'h0000, 0, 3'b111, 6'h3F, "R2 low boot 0000");
    memRead(16'h0FFF, 0, 3'b111, 6'h3F, "R2 low boot 0FFF");
    memRead(16'hE123, 0, 3'b111, 6'h3F, "R3 high boot E123");
    memRead(16'hC000, 0, 3'b111, 6'h3C, "R1 reset page C000");
    memRead(16'hD000, 0, 3'b111, 6'h3D, "R1 reset page D000");
  endtask

  task automatic testRam();
    memRead(16'h1000, 1, 3'b110, 0, "R6 bank0 1000");
    memRead(16'h4000, 1, 3'b101, 0, "R6 bank1 4000");
    memRead(16'hBFFF, 1, 3'b011, 0, "R6 bank2 BFFF");
    memWrite(16'h5000, 3'b101, 0, "R7 ram write 5000");
  endtask

  task automatic testRomWrites();
    memWrite(16'h0010, 3'b111, 1, "R7 write low boot");
    memWrite(16'hE010, 3'b111, 1, "R7 write high boot");
    memWrite(16'hC000, 3'b111, 1, "R7 write paged");
  endtask

  task automatic testNoCycle();
    @(negedge clk);
    addr = 16'h0000; mreqN = 1; rdN = 0; wrN = 1; #2;
    chk("R8 no mreq romSelN", romSelN, 1);
    chk("R8 no mreq ramSelN", ramSelN, 3'b111);
    @(negedge clk);
    addr = 16'h2000; mreqN = 0; rdN = 0; wrN = 0; #2;
    chk("R8 rd+wr romSelN", romSelN, 1);
    chk("R8 rd+wr ramSelN", ramSelN, 3'b111);
    chk("R8 rd+wr ramWeN", ramWeN, 1);
    idle();
  endtask

  task automatic testControl();
    ioWrite(8'd33, 8'h45);  // R4: out of range, ignored
    memRead(16'h0000, 0, 3'b111, 6'h3F, "R4 port33 ignored low");
    memRead(16'hC000, 0, 3'b111, 6'h3C, "R4 port33 ignored page");
    ioWrite(8'd32, 8'h45);  // bit6=1, page 5
    memRead(16'h0000, 1, 3'b110, 0, "R4 overlay off 0000");
    memWrite(16'h0000, 3'b110, 0, "R6 ram write 0000");
    memRead(16'hE000, 0, 3'b111, 6'h16, "R5 page5 E000");
    memRead(16'hC000, 0, 3'b111, 6'h14, "R5 page5 C000");
    memRead(16'hFFFF, 0, 3'b111, 6'h17, "R5 page5 FFFF");
    ioWrite(8'd0, 8'h0A);   // bit6=0, page 10
    memRead(16'h0000, 0, 3'b111, 6'h3F, "R4 overlay back 0000");
    memRead(16'hE000, 0, 3'b111, 6'h3F, "R3 overlay back E000");
    memRead(16'hD000, 0, 3'b111, 6'h29, "R5 page10 D000");
  endtask

  task automatic testSyncReset();
    ioWrite(8'd5, 8'h47);   // overlay off, page 7
    @(negedge clk);
    addr = 16'hC000; mreqN = 0; rdN = 0; wrN = 1; rstN = 0;
    #2;
    chk("R9 before edge flashHi", flashHi, 6'h1C);
    @(posedge clk); #2;
    chk("R9 after edge flashHi", flashHi, 6'h3C);
    @(negedge clk);
    rstN = 1; addr = 16'h0000; #2;
    chk("R9 overlay restored romSelN", romSelN, 0);
    chk("R9 overlay restored flashHi", flashHi, 6'h3F);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testRam();
    testRomWrites();
    testNoCycle();
    testControl();
    testSyncReset();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule